// File: doc/BRIEF.md
# Six-bit minifloat adder

This block adds or subtracts two numbers held in a six-bit floating-point word and registers the result. A word is a sign bit on top, a two-bit exponent field below it and a three-bit fraction in the low bits. The fraction is a pure binary fraction 0.f2f1f0, and its leading one is stored rather than implied. The exponent field carries a bias of one, so a word's value is (-1)^sign × 0.f2f1f0 × 2^(field-1). A fraction of 000 means zero, whatever the other bits hold. Positive normalized magnitudes therefore run from 0.25 (0_00_100) up to 3.5 (0_11_111).

Each operand is brought to normal form first. The operand with the smaller magnitude is then shifted right to the larger one's exponent, and the bits that fall off are dropped. The two magnitudes are added or subtracted, and the result is renormalized and truncated. A result too large for the format saturates and raises a flag. A result too small, or exactly zero, becomes the all-zero word and raises a zero flag. A subtract input flips the sign of the second operand. All outputs are registered and show the result one clock after the operands.

Top module: `mf_adder`

## Requirements
- R1: While reset is asserted, sum_o, ovf_o and zero_o are all 0.
- R2: Outputs reflect the operands one rising clock edge after they are presented. Any non-zero sum_o has fraction bit 2 set, meaning it is in normal form.
- R3: The smaller operand is aligned by a right shift of its fraction equal to the exponent difference, with shifted-out bits lost. 0_10_100 + 0_01_111 gives 0_10_111, and 1_11_111 + 0_00_100 gives 1_11_111.
- R4: A carry out of the fraction add shifts the fraction right by one, drops the low bit and raises the exponent by one. 0_01_100 + 0_01_100 gives 0_10_100, and 0_01_111 + 0_01_110 gives 0_10_110.
- R5: After a cancelling subtract the fraction is shifted left until bit 2 is 1, and the exponent drops by one per shift. 0_10_111 − 0_10_110 gives 0_00_100.
- R6: If the exponent would exceed field value 3, ovf_o is 1 and sum_o is the sign followed by 11111. Both 0_11_100 + 0_11_100 and 1_11_111 + 1_11_100 overflow this way.
- R7: If the exponent would fall below field value 0, sum_o is 000000, zero_o is 1 and ovf_o is 0. Example: 0_00_101 − 0_00_100.
- R8: An exactly zero result is 000000 with zero_o = 1, never a negative zero. Example: 1_10_101 − 1_10_101.
- R9: sub_i = 1 inverts the sign bit (bit 5) of b_i before the operation. 0_01_100 − 1_01_100 gives 0_10_100.
- R10: An operand whose fraction field is 000 is zero, whatever its sign and exponent. 1_11_000 + 0_00_100 gives 0_00_100.
- R11: An operand with fraction bit 2 clear but a non-zero fraction is normalized before use. It becomes zero if its exponent would drop below field value 0. 0_11_001 + 0_00_000 gives 0_01_100, and 0_00_011 + 0_00_100 gives 0_00_100.
- R12: The result takes the sign of the operand with the larger magnitude. 0_01_100 + 1_10_100 gives 1_01_100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| a_i | input | 6 | First operand {sign, exponent[1:0], fraction[2:0]} |
| b_i | input | 6 | Second operand, same layout |
| sub_i | input | 1 | 1 selects a_i − b_i, 0 selects a_i + b_i |
| sum_o | output | 6 | Registered result in the same layout |
| ovf_o | output | 1 | Registered flag: result saturated |
| zero_o | output | 1 | Registered flag: result is the zero word |

## Verification
A carry out of the fraction add and the saturation at the top exponent can occur in the same cycle. The renormalizing shift would then push the exponent past field value 3, so the saturated word must replace the shifted one. The bench provokes this with same-sign operands at exponent field 3, both directly and through sub_i with opposite signs. It judges the outcome against an integer reference model that works in units of 1/64. The exhaustive sweep of all operand pairs in both modes covers the same meeting point, together with cancellation that ends in an exponent underflow.

// File: rtl/mf_pkg.sv
package mf_pkg;
  localparam int DEF_EXP_W  = 2;
  localparam int DEF_FRAC_W = 3;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } mf_op_e;
endpackage

// File: rtl/mf_prenorm.sv
module mf_prenorm #(
  parameter int EXP_W  = mf_pkg::DEF_EXP_W,
  parameter int FRAC_W = mf_pkg::DEF_FRAC_W
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              zero_o
);
  localparam int LZ_W = $clog2(FRAC_W + 1);
  localparam int CW   = ((EXP_W > LZ_W) ? EXP_W : LZ_W) + 1;

  logic [LZ_W-1:0] lz;
  logic            hit;
  logic [CW-1:0]   exp_w, lz_w, exp_d;

  // leading-zero count of the fraction
  always_comb begin
    lz  = '0;
    hit = 1'b0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (frac_i[i]) hit = 1'b1;
        else           lz  = lz + 1'b1;
      end
    end
  end

  assign exp_w  = CW'(exp_i);
  assign lz_w   = CW'(lz);
  assign exp_d  = exp_w - lz_w;
  assign zero_o = !hit || (exp_w < lz_w);
  assign exp_o  = zero_o ? '0 : exp_d[EXP_W-1:0];
  assign frac_o = zero_o ? '0 : (frac_i << lz);
endmodule

// File: rtl/mf_align.sv
module mf_align
  import mf_pkg::*;
#(
  parameter int EXP_W  = mf_pkg::DEF_EXP_W,
  parameter int FRAC_W = mf_pkg::DEF_FRAC_W
) (
  input  logic              sgn_a_i,
  input  logic [EXP_W-1:0]  exp_a_i,
  input  logic [FRAC_W-1:0] frac_a_i,
  input  logic              sgn_b_i,
  input  logic [EXP_W-1:0]  exp_b_i,
  input  logic [FRAC_W-1:0] frac_b_i,
  output mf_op_e            op_o,
  output logic              sgn_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W-1:0] big_frac_o,
  output logic [FRAC_W-1:0] small_frac_o
);
  logic              swap;
  logic [EXP_W-1:0]  small_exp;
  logic [FRAC_W-1:0] small_raw;
  logic [EXP_W-1:0]  shift;

  // b wins on a larger exponent, or on a larger fraction at equal exponents
  assign swap = (exp_b_i > exp_a_i) || ((exp_b_i == exp_a_i) && (frac_b_i > frac_a_i));

  always_comb begin
    if (swap) begin
      sgn_o      = sgn_b_i;
      exp_o      = exp_b_i;
      big_frac_o = frac_b_i;
      small_exp  = exp_a_i;
      small_raw  = frac_a_i;
    end else begin
      sgn_o      = sgn_a_i;
      exp_o      = exp_a_i;
      big_frac_o = frac_a_i;
      small_exp  = exp_b_i;
      small_raw  = frac_b_i;
    end
  end

  assign shift        = exp_o - small_exp;
  assign small_frac_o = small_raw >> shift;
  assign op_o         = (sgn_a_i ^ sgn_b_i) ? OP_SUB : OP_ADD;
endmodule

// File: rtl/mf_addsub.sv
module mf_addsub
  import mf_pkg::*;
#(
  parameter int FRAC_W = mf_pkg::DEF_FRAC_W
) (
  input  mf_op_e            op_i,
  input  logic [FRAC_W-1:0] big_i,
  input  logic [FRAC_W-1:0] small_i,
  output logic [FRAC_W:0]   raw_o
);
  always_comb begin
    unique case (op_i)
      OP_SUB:  raw_o = {1'b0, big_i} - {1'b0, small_i};
      default: raw_o = {1'b0, big_i} + {1'b0, small_i};
    endcase
  end
endmodule

// File: rtl/mf_renorm.sv
module mf_renorm #(
  parameter int EXP_W  = mf_pkg::DEF_EXP_W,
  parameter int FRAC_W = mf_pkg::DEF_FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              sgn_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W:0]   raw_i,
  output logic [WORD_W-1:0] word_o,
  output logic              ovf_o,
  output logic              zero_o
);
  logic [EXP_W-1:0]  ln_exp;
  logic [FRAC_W-1:0] ln_frac;
  logic              ln_zero;
  logic [EXP_W-1:0]  exp_inc;

  // left normalization for the no-carry path
  mf_prenorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_lnorm (
    .exp_i  (exp_i),
    .frac_i (raw_i[FRAC_W-1:0]),
    .exp_o  (ln_exp),
    .frac_o (ln_frac),
    .zero_o (ln_zero)
  );

  assign exp_inc = exp_i + 1'b1;

  always_comb begin
    word_o = '0;
    ovf_o  = 1'b0;
    zero_o = 1'b0;
    if (raw_i[FRAC_W]) begin
      if (&exp_i) begin
        ovf_o  = 1'b1;
        word_o = {sgn_i, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};
      end else begin
        word_o = {sgn_i, exp_inc, raw_i[FRAC_W:1]};
      end
    end else if (ln_zero) begin
      zero_o = 1'b1;
    end else begin
      word_o = {sgn_i, ln_exp, ln_frac};
    end
  end
endmodule

// File: rtl/mf_adder.sv
module mf_adder
  import mf_pkg::*;
#(
  parameter int EXP_W  = mf_pkg::DEF_EXP_W,
  parameter int FRAC_W = mf_pkg::DEF_FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic              sub_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              ovf_o,
  output logic              zero_o
);
  localparam int N_OPS = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // operand conditioning
  logic [WORD_W-1:0] op_word [N_OPS];
  logic              pn_sgn  [N_OPS];
  logic [EXP_W-1:0]  pn_exp  [N_OPS];
  logic [FRAC_W-1:0] pn_frac [N_OPS];
  logic              pn_zero [N_OPS];

  assign op_word[0] = a_i;
  assign op_word[1] = {b_i[WORD_W-1] ^ sub_i, b_i[WORD_W-2:0]};

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    assign pn_sgn[g] = op_word[g][WORD_W-1];
    mf_prenorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pn (
      .exp_i  (op_word[g][WORD_W-2:FRAC_W]),
      .frac_i (op_word[g][FRAC_W-1:0]),
      .exp_o  (pn_exp[g]),
      .frac_o (pn_frac[g]),
      .zero_o (pn_zero[g])
    );
  end

  // datapath
  mf_op_e            al_op;
  logic              al_sgn;
  logic [EXP_W-1:0]  al_exp;
  logic [FRAC_W-1:0] al_big, al_small;
  logic [FRAC_W:0]   raw;

  mf_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .sgn_a_i      (pn_sgn[0]),
    .exp_a_i      (pn_exp[0]),
    .frac_a_i     (pn_frac[0]),
    .sgn_b_i      (pn_sgn[1]),
    .exp_b_i      (pn_exp[1]),
    .frac_b_i     (pn_frac[1]),
    .op_o         (al_op),
    .sgn_o        (al_sgn),
    .exp_o        (al_exp),
    .big_frac_o   (al_big),
    .small_frac_o (al_small)
  );

  mf_addsub #(.FRAC_W(FRAC_W)) u_addsub (
    .op_i    (al_op),
    .big_i   (al_big),
    .small_i (al_small),
    .raw_o   (raw)
  );

  logic [WORD_W-1:0] sum_d;
  logic              ovf_d, zero_d;
  logic              both_zero;

  mf_renorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_renorm (
    .sgn_i  (al_sgn),
    .exp_i  (al_exp),
    .raw_i  (raw),
    .word_o (sum_d),
    .ovf_o  (ovf_d),
    .zero_o (zero_d)
  );

  assign both_zero = pn_zero[0] && pn_zero[1];

  // output registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sum_o  <= '0;
      ovf_o  <= 1'b0;
      zero_o <= 1'b0;
    end else begin
      sum_o  <= both_zero ? '0 : sum_d;
      ovf_o  <= ovf_d && !both_zero;
      zero_o <= zero_d || both_zero;
    end
  end
endmodule

// File: rtl/mf_adder_chk.sv
module mf_adder_chk #(
  parameter int EXP_W  = mf_pkg::DEF_EXP_W,
  parameter int FRAC_W = mf_pkg::DEF_FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_q,
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic              sub_i,
  input logic [WORD_W-1:0] sum_o,
  input logic              ovf_o,
  input logic              zero_o
);
  // R2
  normal_form_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (sum_o != '0) |-> sum_o[FRAC_W-1]);

  // R7
  zero_word_chk: assert property (@(posedge clk) disable iff (!rst_q)
    zero_o |-> (sum_o == '0));

  // R6
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ovf_o |-> (sum_o[WORD_W-2:0] == '1));

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !(ovf_o && zero_o));

  // R8
  self_cancel_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (sub_i && (a_i == b_i)) |=> (zero_o && (sum_o == '0)));

  // R10
  zero_ops_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ((a_i[FRAC_W-1:0] == '0) && (b_i[FRAC_W-1:0] == '0)) |=> zero_o);
endmodule

bind mf_adder mf_adder_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_chk (
  .clk    (clk),
  .rst_q  (rst_q),
  .a_i    (a_i),
  .b_i    (b_i),
  .sub_i  (sub_i),
  .sum_o  (sum_o),
  .ovf_o  (ovf_o),
  .zero_o (zero_o)
);

// File: tb/test_mf_adder.sv
module test_mf_adder;
  logic       clk;
  logic       rst_n;
  logic [5:0] a_i, b_i;
  logic       sub_i;
  logic [5:0] sum_o;
  logic       ovf_o, zero_o;

  int n_chk;
  int n_fail;

  mf_adder i_mf_adder (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sub_i),
    .sum_o  (sum_o),
    .ovf_o  (ovf_o),
    .zero_o (zero_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [5:0] ew, input logic eo, input logic ez);
    n_chk++;
    if (sum_o !== ew || ovf_o !== eo || zero_o !== ez) begin
      n_fail++;
      $display("FAIL %s: got sum=%b ovf=%b zero=%b, expected sum=%b ovf=%b zero=%b",
               tag, sum_o, ovf_o, zero_o, ew, eo, ez);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic run(input logic [5:0] a, input logic [5:0] b, input logic s,
                     input string tag, input logic [5:0] ew, input logic eo, input logic ez);
    a_i = a; b_i = b; sub_i = s;
    @(negedge clk);
    check(tag, ew, eo, ez);
  endtask

  // reference model: magnitudes in units of 1/64
  function automatic void norm(input logic [5:0] w, output int e, output int m);
    int f;
    f = int'(w[2:0]);
    e = int'(w[4:3]);
    if (f == 0) begin e = -1; m = 0; return; end
    while (f < 4) begin f = f * 2; e = e - 1; end
    if (e < 0) begin e = -1; m = 0; end
    else m = f << (e + 2);
  endfunction

  function automatic logic [7:0] ref_add(input logic [5:0] a, input logic [5:0] b, input logic s);
    int ea, eb, ma, mb, eh, mh, ml, r;
    logic sa, sb, sh, ov, z;
    logic [5:0] w;
    sa = a[5];
    sb = b[5] ^ s;
    norm(a, ea, ma);
    norm(b, eb, mb);
    if (eb > ea || (eb == ea && mb > ma)) begin eh = eb; mh = mb; sh = sb; ml = ma; end
    else begin eh = ea; mh = ma; sh = sa; ml = mb; end
    if (mh == 0) r = 0;
    else begin
      ml = (ml >> (eh + 2)) << (eh + 2);
      r  = (sa == sb) ? mh + ml : mh - ml;
    end
    ov = 1'b0; z = 1'b1; w = 6'b0;
    if (r >= 256) begin ov = 1'b1; z = 1'b0; w = {sh, 5'b11111}; end
    else begin
      for (int k = 3; k >= 0; k--) begin
        if (z && r >= (16 << k)) begin
          z = 1'b0;
          w = {sh, 2'(k), 3'(r >> (k + 2))};
        end
      end
    end
    return {ov, z, w};
  endfunction

  task automatic t_reset();
    check("R1 reset", 6'b0, 1'b0, 1'b0);
  endtask

  task automatic t_align();
    run(6'b0_10_100, 6'b0_01_111, 1'b0, "R3 shift by one", 6'b0_10_111, 1'b0, 1'b0);
    run(6'b1_11_111, 6'b0_00_100, 1'b0, "R3 shifted out", 6'b1_11_111, 1'b0, 1'b0);
  endtask

  task automatic t_carry();
    run(6'b0_01_100, 6'b0_01_100, 1'b0, "R4 carry exact", 6'b0_10_100, 1'b0, 1'b0);
    run(6'b0_01_111, 6'b0_01_110, 1'b0, "R4 carry truncate", 6'b0_10_110, 1'b0, 1'b0);
  endtask

  task automatic t_cancel();
    run(6'b0_10_111, 6'b0_10_110, 1'b1, "R5 left renorm", 6'b0_00_100, 1'b0, 1'b0);
  endtask

  task automatic t_overflow();
    run(6'b0_11_100, 6'b0_11_100, 1'b0, "R6 positive", 6'b0_11_111, 1'b1, 1'b0);
    run(6'b1_11_111, 6'b1_11_100, 1'b0, "R6 negative", 6'b1_11_111, 1'b1, 1'b0);
    run(6'b1_11_110, 6'b0_11_101, 1'b1, "R6 via subtract", 6'b1_11_111, 1'b1, 1'b0);
  endtask

  task automatic t_underflow();
    run(6'b0_00_101, 6'b0_00_100, 1'b1, "R7 underflow", 6'b0, 1'b0, 1'b1);
  endtask

  task automatic t_exact_cancel();
    run(6'b1_10_101, 6'b1_10_101, 1'b1, "R8 self subtract", 6'b0, 1'b0, 1'b1);
    run(6'b1_01_110, 6'b0_01_110, 1'b0, "R8 opposite add", 6'b0, 1'b0, 1'b1);
  endtask

  task automatic t_sub_ctl();
    run(6'b0_01_100, 6'b1_01_100, 1'b1, "R9 minus negative", 6'b0_10_100, 1'b0, 1'b0);
    run(6'b0_01_100, 6'b1_01_100, 1'b0, "R9 plain add", 6'b0, 1'b0, 1'b1);
  endtask

  task automatic t_zero_op();
    run(6'b1_11_000, 6'b0_00_100, 1'b0, "R10 zero with exponent", 6'b0_00_100, 1'b0, 1'b0);
    run(6'b0_10_101, 6'b1_01_000, 1'b1, "R10 zero subtrahend", 6'b0_10_101, 1'b0, 1'b0);
  endtask

  task automatic t_unnorm();
    run(6'b0_11_001, 6'b0_00_000, 1'b0, "R11 normalize input", 6'b0_01_100, 1'b0, 1'b0);
    run(6'b0_00_011, 6'b0_00_100, 1'b0, "R11 input flushed", 6'b0_00_100, 1'b0, 1'b0);
  endtask

  task automatic t_sign();
    run(6'b0_01_100, 6'b1_10_100, 1'b0, "R12 larger negative", 6'b1_01_100, 1'b0, 1'b0);
    run(6'b1_01_100, 6'b1_10_110, 1'b1, "R12 larger positive", 6'b0_10_100, 1'b0, 1'b0);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 64; j++) begin
        for (int k = 0; k < 2; k++) begin
          logic [7:0] r;
          r = ref_add(6'(i), 6'(j), k[0]);
          if (r[7])      run(6'(i), 6'(j), k[0], "R6 sweep", r[5:0], r[7], r[6]);
          else if (r[6]) run(6'(i), 6'(j), k[0], "R7 sweep", r[5:0], r[7], r[6]);
          else           run(6'(i), 6'(j), k[0], "R2 sweep", r[5:0], r[7], r[6]);
        end
      end
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    n_chk  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    a_i    = 6'b0_11_111;
    b_i    = 6'b0_11_111;
    sub_i  = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_align();
    t_carry();
    t_cancel();
    t_overflow();
    t_underflow();
    t_exact_cancel();
    t_sub_ctl();
    t_zero_op();
    t_unnorm();
    t_sign();
    t_sweep();
    finish_run();
  end
endmodule